// File: doc/BRIEF.md
# Staggered Half-Width Integer Adder

This block is a 32-bit integer add/subtract unit clocked at twice the core rate. It splits each operation into two 16-bit slices that run one fast cycle apart. The low half of the result appears first, on its own output with a valid strobe and a tag, so that a consumer such as an address generator can start early. The high half follows one fast cycle later. The full result and its zero, sign, carry and overflow flags arrive one cycle after that.

Each source operand can name the destination tag of an earlier operation that is still in the pipe. The unit then takes that operation's slice results directly from its own stage registers. As a result, a chain of dependent adds issues on consecutive fast cycles: the consumer's low slice reads the producer's low half, and one cycle later its high slice reads the producer's high half. A new operation is accepted on every fast cycle, and the unit never stalls.

Top module: `stagger_adder`

## Requirements
- R1: An operation presented with `in_valid`=1 gives `lo_valid`=1 on the next cycle. In that cycle `lo_data` holds bits 15:0 of the result and `lo_tag` holds the operation's tag. `lo_valid` is 0 in the cycle after any cycle with `in_valid`=0.
- R2: `hi_valid` is asserted one cycle after `lo_valid`, with `hi_data` holding bits 31:16 of the same result, including the carry out of the low slice.
- R3: `res_valid` is asserted one cycle after `hi_valid`, with `res_data` holding the full 32-bit result and `res_tag` holding the operation's tag.
- R4: `in_sub`=0 computes a+b modulo 2^32. `in_sub`=1 computes a-b modulo 2^32, borrowing correctly across the 16-bit slice boundary.
- R5: With the result come four flags. `res_zero` is 1 when the result is 0. `res_sign` is result bit 31. `res_carry` is the carry out of bit 31 of a+b, or of a+~b+1 for subtract, so 1 means no borrow. `res_ovf` is 1 on two's-complement signed overflow.
- R6: When `src_a_en` (or `src_b_en`) is 1 and its tag equals the tag of the valid operation issued one cycle earlier, that operand is replaced by the earlier operation's full result.
- R7: When there is no one-cycle match, and the source tag equals the tag of the valid operation issued two cycles earlier, the operand is replaced by that operation's result.
- R8: When both earlier operations match, the one issued one cycle earlier supplies the operand.
- R9: The operand bus value is used unchanged when the source enable is 0, when no tag matches, or when the matching slot held no valid operation.
- R10: Reset (`rst_n`=0, asynchronous) clears all valid outputs at once. Operations in flight are dropped and cannot be forwarded afterwards.
- R11: Operations are accepted on every cycle with no stall, so consecutive issues give consecutive results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_sub | input | 1 | 1 = subtract, 0 = add |
| in_a | input | 32 | First operand bus value |
| in_b | input | 32 | Second operand bus value |
| in_tag | input | 4 | Destination tag of this operation |
| src_a_en | input | 1 | Allow forwarding for operand a |
| src_a_tag | input | 4 | Producer tag for operand a |
| src_b_en | input | 1 | Allow forwarding for operand b |
| src_b_tag | input | 4 | Producer tag for operand b |
| lo_valid | output | 1 | Low half strobe |
| lo_data | output | 16 | Result bits 15:0 |
| lo_tag | output | 4 | Tag of the low half |
| hi_valid | output | 1 | High half strobe |
| hi_data | output | 16 | Result bits 31:16 |
| res_valid | output | 1 | Full result strobe |
| res_data | output | 32 | Full result |
| res_tag | output | 4 | Tag of the full result |
| res_zero | output | 1 | Result is zero |
| res_sign | output | 1 | Result bit 31 |
| res_carry | output | 1 | Carry out of bit 31 |
| res_ovf | output | 1 | Signed overflow |

## Verification
On every cycle, the assertions check the timing of the three strobes, tag travel, and that the full result agrees with the halves shown earlier. When no forwarding is requested, they also check the low-half sum and difference, and the one-cycle forwarding of the low slice. Only the bench's scenarios can show the carry into the high slice when forwarding is active, the distance-two and priority choices, the flags across corner operands, and the loss of in-flight producers on reset. The bench checks these against a 32-bit reference adder.

// File: rtl/stagger_adder.sv
module stagger_adder #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_sub,
  input  logic [DATA_W-1:0]   in_a,
  input  logic [DATA_W-1:0]   in_b,
  input  logic [TAG_W-1:0]    in_tag,
  input  logic                src_a_en,
  input  logic [TAG_W-1:0]    src_a_tag,
  input  logic                src_b_en,
  input  logic [TAG_W-1:0]    src_b_tag,
  output logic                lo_valid,
  output logic [DATA_W/2-1:0] lo_data,
  output logic [TAG_W-1:0]    lo_tag,
  output logic                hi_valid,
  output logic [DATA_W/2-1:0] hi_data,
  output logic                res_valid,
  output logic [DATA_W-1:0]   res_data,
  output logic [TAG_W-1:0]    res_tag,
  output logic                res_zero,
  output logic                res_sign,
  output logic                res_carry,
  output logic                res_ovf
);
  localparam int HW = DATA_W / 2;

  logic          s1_sub, s1_c;
  logic [HW-1:0] s1_ahi, s1_bhi;
  logic [1:0]    s1_asel, s1_bsel;
  logic          s2_c, s2_ovf;
  logic [HW-1:0] s2_lo;
  logic [TAG_W-1:0] s2_tag;

  // issue stage: pick forwarded low slices, nearest producer first
  logic a_d1, a_d2, b_d1, b_d2;
  assign a_d1 = src_a_en && lo_valid && (lo_tag == src_a_tag);
  assign a_d2 = src_a_en && hi_valid && (s2_tag == src_a_tag) && !a_d1;
  assign b_d1 = src_b_en && lo_valid && (lo_tag == src_b_tag);
  assign b_d2 = src_b_en && hi_valid && (s2_tag == src_b_tag) && !b_d1;

  logic [HW-1:0] a_lo, b_lo, b_lo_x, lo_sum;
  logic          lo_c;
  assign a_lo   = a_d1 ? lo_data : (a_d2 ? s2_lo : in_a[HW-1:0]);
  assign b_lo   = b_d1 ? lo_data : (b_d2 ? s2_lo : in_b[HW-1:0]);
  assign b_lo_x = b_lo ^ {HW{in_sub}};
  assign {lo_c, lo_sum} = {1'b0, a_lo} + {1'b0, b_lo_x} + {{HW{1'b0}}, in_sub};

  // high stage: producers have moved one stage on
  logic [HW-1:0] a_hi, b_hi, b_hi_x, hi_sum;
  logic          hi_c, hi_ovf;
  assign a_hi   = s1_asel[0] ? hi_data : (s1_asel[1] ? res_data[DATA_W-1:HW] : s1_ahi);
  assign b_hi   = s1_bsel[0] ? hi_data : (s1_bsel[1] ? res_data[DATA_W-1:HW] : s1_bhi);
  assign b_hi_x = b_hi ^ {HW{s1_sub}};
  assign {hi_c, hi_sum} = {1'b0, a_hi} + {1'b0, b_hi_x} + {{HW{1'b0}}, s1_c};
  assign hi_ovf = (a_hi[HW-1] == b_hi_x[HW-1]) && (hi_sum[HW-1] != a_hi[HW-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_valid  <= 1'b0;
      hi_valid  <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      lo_valid  <= in_valid;
      hi_valid  <= lo_valid;
      res_valid <= hi_valid;
    end
  end

  always_ff @(posedge clk) begin
    lo_data   <= lo_sum;
    lo_tag    <= in_tag;
    s1_c      <= lo_c;
    s1_sub    <= in_sub;
    s1_ahi    <= in_a[DATA_W-1:HW];
    s1_bhi    <= in_b[DATA_W-1:HW];
    s1_asel   <= {a_d2, a_d1};
    s1_bsel   <= {b_d2, b_d1};
    hi_data   <= hi_sum;
    s2_lo     <= lo_data;
    s2_tag    <= lo_tag;
    s2_c      <= hi_c;
    s2_ovf    <= hi_ovf;
    res_data  <= {hi_data, s2_lo};
    res_tag   <= s2_tag;
    res_zero  <= ~|{hi_data, s2_lo};
    res_sign  <= hi_data[HW-1];
    res_carry <= s2_c;
    res_ovf   <= s2_ovf;
  end

  AST_LO_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> lo_valid && lo_tag == $past(in_tag)); // R1
  AST_LO_ONLY_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !lo_valid); // R1
  AST_LO_ADD_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_sub && !src_a_en && !src_b_en |=>
      lo_data == HW'($past(in_a[HW-1:0]) + $past(in_b[HW-1:0]))); // R1
  AST_LO_SUB_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_sub && !src_a_en && !src_b_en |=>
      lo_data == HW'($past(in_a[HW-1:0]) - $past(in_b[HW-1:0]))); // R4
  AST_HI_FOLLOWS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    lo_valid |=> hi_valid); // R2
  AST_RES_FOLLOWS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    hi_valid |=> res_valid && res_data[DATA_W-1:HW] == $past(hi_data)); // R3
  AST_RES_LO_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_data[HW-1:0] == $past(lo_data, 2) && res_tag == $past(lo_tag, 2)); // R3
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_zero == (res_data == '0)); // R5
  AST_FWD_LO_NEAR: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_sub && src_a_en && lo_valid && src_a_tag == lo_tag && !src_b_en |=>
      lo_data == HW'($past(lo_data) + $past(in_b[HW-1:0]))); // R6
endmodule

// File: tb/stagger_adder_tb.sv
module stagger_adder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sub = 1'b0;
  logic [31:0] in_a = '0, in_b = '0;
  logic [3:0] in_tag = '0, src_a_tag = '0, src_b_tag = '0;
  logic src_a_en = 1'b0, src_b_en = 1'b0;
  logic lo_valid, hi_valid, res_valid;
  logic [15:0] lo_data, hi_data;
  logic [3:0] lo_tag, res_tag;
  logic [31:0] res_data;
  logic res_zero, res_sign, res_carry, res_ovf;

  always #(CLK_PERIOD/2) clk = ~clk;

  stagger_adder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sub(in_sub),
    .in_a(in_a), .in_b(in_b), .in_tag(in_tag),
    .src_a_en(src_a_en), .src_a_tag(src_a_tag), .src_b_en(src_b_en), .src_b_tag(src_b_tag),
    .lo_valid(lo_valid), .lo_data(lo_data), .lo_tag(lo_tag),
    .hi_valid(hi_valid), .hi_data(hi_data),
    .res_valid(res_valid), .res_data(res_data), .res_tag(res_tag),
    .res_zero(res_zero), .res_sign(res_sign), .res_carry(res_carry), .res_ovf(res_ovf));

  logic [31:0] exp_res [0:4095];
  logic        exp_v   [0:4095];
  logic [3:0]  exp_tag [0:4095];
  logic        exp_c   [0:4095];
  logic        exp_o   [0:4095];
  string       exp_rq  [0:4095];
  int cyc = 4, total = 0, bad = 0;
  logic [31:0] rng = 32'h1234_5678;

  function automatic logic [31:0] next_rnd();
    rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
    return rng;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", rq, what, got, exp);
    end
  endtask

  task automatic check_outs();
    int j = cyc - 1, k = cyc - 2, m = cyc - 3;
    chk(lo_valid == exp_v[j], "R1/R11", "lo_valid", 32'(lo_valid), 32'(exp_v[j]));
    if (exp_v[j]) begin
      chk(lo_data == exp_res[j][15:0], {"R1 ", exp_rq[j]}, "lo_data", 32'(lo_data), 32'(exp_res[j][15:0]));
      chk(lo_tag == exp_tag[j], "R1", "lo_tag", 32'(lo_tag), 32'(exp_tag[j]));
    end
    chk(hi_valid == exp_v[k], "R2", "hi_valid", 32'(hi_valid), 32'(exp_v[k]));
    if (exp_v[k])
      chk(hi_data == exp_res[k][31:16], {"R2 ", exp_rq[k]}, "hi_data", 32'(hi_data), 32'(exp_res[k][31:16]));
    chk(res_valid == exp_v[m], "R3", "res_valid", 32'(res_valid), 32'(exp_v[m]));
    if (exp_v[m]) begin
      chk(res_data == exp_res[m], {"R3 ", exp_rq[m]}, "res_data", res_data, exp_res[m]);
      chk(res_tag == exp_tag[m], "R3", "res_tag", 32'(res_tag), 32'(exp_tag[m]));
      chk({res_zero, res_sign, res_carry, res_ovf} ==
          {exp_res[m] == 32'd0, exp_res[m][31], exp_c[m], exp_o[m]}, "R5", "flags zscv",
          32'({res_zero, res_sign, res_carry, res_ovf}),
          32'({exp_res[m] == 32'd0, exp_res[m][31], exp_c[m], exp_o[m]}));
    end
  endtask

  function automatic logic [31:0] pick(input logic en, input logic [3:0] t, input logic [31:0] bus);
    if (en && exp_v[cyc-1] && exp_tag[cyc-1] == t) return exp_res[cyc-1];
    if (en && exp_v[cyc-2] && exp_tag[cyc-2] == t) return exp_res[cyc-2];
    return bus;
  endfunction

  task automatic issue(input logic v, input logic sub, input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] tag, input logic ea, input logic [3:0] ta,
                       input logic eb, input logic [3:0] tb, input string rq);
    logic [31:0] av, bv, bx;
    logic [32:0] s;
    @(negedge clk);
    check_outs();
    av = pick(ea, ta, a);
    bv = pick(eb, tb, b);
    bx = sub ? ~bv : bv;
    s  = {1'b0, av} + {1'b0, bx} + 33'(sub);
    exp_v[cyc] = v; exp_res[cyc] = s[31:0]; exp_tag[cyc] = tag; exp_c[cyc] = s[32];
    exp_o[cyc] = (av[31] == bx[31]) && (s[31] != av[31]); exp_rq[cyc] = rq;
    rst_n = 1'b1;
    in_valid = v; in_sub = sub; in_a = a; in_b = b; in_tag = tag;
    src_a_en = ea; src_a_tag = ta; src_b_en = eb; src_b_tag = tb;
    cyc++;
  endtask

  task automatic rst_pulse();
    @(negedge clk);
    check_outs();
    rst_n = 1'b0; in_valid = 1'b0;
    exp_v[cyc] = 1'b0; exp_v[cyc-1] = 1'b0; exp_v[cyc-2] = 1'b0;
    #1;
    chk(!lo_valid && !hi_valid && !res_valid, "R10", "valids in reset",
        32'({lo_valid, hi_valid, res_valid}), 32'd0);
    cyc++;
  endtask

  logic [31:0] corner [0:9] = '{32'h0, 32'h1, 32'h7fff, 32'h8000, 32'hffff,
                                32'h10000, 32'h7fffffff, 32'h80000000, 32'hffffffff, 32'h0001ffff};

  initial begin
    for (int i = 0; i < 4096; i++) exp_v[i] = 1'b0;
    rst_pulse(); rst_pulse();
    // R3 R4 R11: all corner pairs, both ops, back to back
    for (int i = 0; i < 10; i++)
      for (int j = 0; j < 10; j++)
        for (int s = 0; s < 2; s++)
          issue(1'b1, s[0], corner[i], corner[j], 4'((i + j + s) % 16), 1'b0, 4'd0, 1'b0, 4'd0,
                (s != 0) ? "R4" : "R3");
    // R6: one-cycle dependent chains on a, b and both
    for (int n = 0; n < 96; n++)
      issue(1'b1, n[0], next_rnd(), next_rnd(), 4'(n % 16),
            n % 3 != 1, 4'((n + 15) % 16), n % 3 != 0, 4'((n + 15) % 16), "R6");
    // R7: two interleaved chains, each consuming from two cycles back
    for (int n = 0; n < 64; n++)
      issue(1'b1, n[1], next_rnd(), next_rnd(), n[0] ? 4'd5 : 4'd6,
            1'b1, n[0] ? 4'd5 : 4'd6, n[2], n[0] ? 4'd5 : 4'd6, "R7");
    // R8: same tag everywhere, nearest producer wins
    for (int n = 0; n < 32; n++)
      issue(1'b1, n[0], next_rnd(), next_rnd(), 4'd3, 1'b1, 4'd3, n[1], 4'd3, "R8");
    // R7 / R9: bubble slots with matching tags
    for (int n = 0; n < 8; n++) begin
      issue(1'b1, 1'b0, next_rnd(), next_rnd(), 4'd9, 1'b0, 4'd0, 1'b0, 4'd0, "R7");
      issue(1'b0, 1'b0, next_rnd(), next_rnd(), 4'd9, 1'b0, 4'd0, 1'b0, 4'd0, "R9");
      issue(1'b1, 1'b1, next_rnd(), next_rnd(), 4'd2, 1'b1, 4'd9, 1'b0, 4'd0, "R7");
      issue(1'b0, 1'b0, next_rnd(), next_rnd(), 4'd2, 1'b0, 4'd0, 1'b0, 4'd0, "R9");
      issue(1'b0, 1'b0, next_rnd(), next_rnd(), 4'd2, 1'b0, 4'd0, 1'b0, 4'd0, "R9");
      issue(1'b1, 1'b0, next_rnd(), next_rnd(), 4'd4, 1'b1, 4'd2, 1'b1, 4'd2, "R9");
    end
    // R9: enable low with matching tag, enable high with no match, distance three
    for (int n = 0; n < 24; n++) begin
      issue(1'b1, n[0], next_rnd(), next_rnd(), 4'd11, 1'b0, 4'd11, 1'b0, 4'd11, "R9");
      issue(1'b1, n[1], next_rnd(), next_rnd(), 4'd12, 1'b1, 4'd13, 1'b1, 4'd14, "R9");
      issue(1'b1, 1'b0, next_rnd(), next_rnd(), 4'd1, 1'b0, 4'd0, 1'b0, 4'd0, "R9");
      issue(1'b1, 1'b1, next_rnd(), next_rnd(), 4'd15, 1'b1, 4'd11, 1'b0, 4'd0, "R9");
    end
    // R10: reset with operations in flight, then try to forward from them
    for (int n = 0; n < 4; n++) begin
      issue(1'b1, 1'b0, next_rnd(), next_rnd(), 4'd7, 1'b0, 4'd0, 1'b0, 4'd0, "R10");
      issue(1'b1, 1'b1, next_rnd(), next_rnd(), 4'd8, 1'b1, 4'd7, 1'b0, 4'd0, "R10");
      rst_pulse();
      issue(1'b1, 1'b0, next_rnd(), next_rnd(), 4'd6, 1'b1, 4'd8, 1'b1, 4'd7, "R10");
      issue(1'b1, 1'b1, next_rnd(), next_rnd(), 4'd5, 1'b1, 4'd7, 1'b1, 4'd6, "R10");
    end
    for (int n = 0; n < 4; n++)
      issue(1'b0, 1'b0, 32'd0, 32'd0, 4'd0, 1'b0, 4'd0, 1'b0, 4'd0, "R11");
    @(negedge clk);
    check_outs();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL R11 watchdog got=hang exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule